// File: doc/BRIEF.md
# Program Memory Checksum Accumulator

This block forms the 16-bit checksum of a small device image while the words go past. After a start pulse it takes program words one by one, in address order, each marked by a valid strobe. It also takes a configuration word and four identification words as steady inputs. When the word at address 0x3FE has been accepted, the block raises a done flag and presents the result.

A protect input selects how the result is formed, and the block samples it at start. Unprotected, the result adds up every program word from address 0 to 0x3FE and then adds the configuration word masked with 0x01FF. Protected, the program contents are left out. The result is then the masked configuration word plus a 16-bit value packed from the low nibbles of the four identification words. In both cases any carry out of bit 15 is dropped.

The block does not read memory, does not mask individual words and does not handle any file format. It only counts the words it accepts, so a protected run takes exactly as long as an unprotected one.

Top module: `prog_checksum`

## Requirements
- R1: After reset, `checksum` is 0 and `done` is low.
- R2: A `start` pulse clears the running sum, sets the word address to 0 and drops `done`. `checksum` reads 0 from the cycle after `start` until the run completes. A `start` during a run abandons that run.
- R3: With protect sampled low, the result is the sum of the 1023 accepted program words (addresses 0x000 to 0x3FE), each zero-extended from 14 bits, plus `cfg_word & 0x01FF`.
- R4: With protect sampled high, the result is `cfg_word & 0x01FF` plus the packed ID. The packed ID puts `id0[3:0]` in bits 15:12, `id1[3:0]` in bits 11:8, `id2[3:0]` in bits 7:4 and `id3[3:0]` in bits 3:0. The upper ID bits are ignored.
- R5: All sums are taken modulo 2^16, so carries beyond bit 15 are discarded.
- R6: A cycle with `word_valid` low neither advances the address nor changes the sum, whatever is on `word_in`.
- R7: In protected mode, accepted words are discarded but still counted, so `done` timing is the same as in unprotected mode.
- R8: `done` rises in the cycle after the word at address 0x3FE is accepted, and not earlier.
- R9: The protect mode is latched at `start`. Changing `protect` during a run does not change that run's formula.
- R10: Once `done` is high, it and `checksum` hold their values until the next `start`. Valid words offered in that time are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that opens a new run |
| word_valid | input | 1 | Marks `word_in` as the next program word |
| word_in | input | 14 | Program word at the current address |
| cfg_word | input | 14 | Configuration word |
| id0 | input | 14 | First ID word (most significant nibble) |
| id1 | input | 14 | Second ID word |
| id2 | input | 14 | Third ID word |
| id3 | input | 14 | Fourth ID word (least significant nibble) |
| protect | input | 1 | Selects the protected formula, sampled at `start` |
| checksum | output | 16 | Result, valid while `done` is high |
| done | output | 1 | High from the cycle after the last word until the next `start` |

## Verification
The assertions check on every cycle the control behaviour. A start clears the state and zeroes the output. An idle cycle leaves the address where it was. Done rises only after the word at the last address is accepted, and it then holds with a stable result. The arithmetic can only be shown by the bench scenarios, which compare each result with a value the bench computes itself. These scenarios cover both formulas, all-ones words that wrap the sum, and the nibble packing with junk in the upper ID bits. They also cover protect toggling in mid-run, a restart in mid-run, and valid gaps filled with noise.

// File: rtl/prog_checksum.sv
module prog_checksum #(
  parameter int WORD_W    = 14,
  parameter int SUM_W     = 16,
  parameter int ADDR_W    = 10,
  parameter int LAST_ADDR = 'h3FE,
  parameter int CFG_MASK  = 'h01FF,
  parameter int NIB_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_in,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic [WORD_W-1:0] id0,
  input  logic [WORD_W-1:0] id1,
  input  logic [WORD_W-1:0] id2,
  input  logic [WORD_W-1:0] id3,
  input  logic              protect,
  output logic [SUM_W-1:0]  checksum,
  output logic              done
);
  localparam int PACK_W = 4 * NIB_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);
  localparam logic [SUM_W-1:0]  MASK = SUM_W'(CFG_MASK);

  logic              busy_q, mode_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SUM_W-1:0]  acc_q, result_q;

  logic              take, last;
  logic [SUM_W-1:0]  addend, acc_next, cfg_part, id_pack, final_sum;
  logic [PACK_W-1:0] nibbles;

  assign take      = busy_q & word_valid;
  assign last      = take & (addr_q == LAST);
  assign addend    = mode_q ? '0 : SUM_W'(word_in);
  assign acc_next  = acc_q + addend;
  assign cfg_part  = SUM_W'(cfg_word) & MASK;
  assign nibbles   = {id0[NIB_W-1:0], id1[NIB_W-1:0], id2[NIB_W-1:0], id3[NIB_W-1:0]};
  assign id_pack   = SUM_W'(nibbles);
  assign final_sum = (mode_q ? id_pack : acc_next) + cfg_part;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      mode_q   <= 1'b0;
      done_q   <= 1'b0;
      addr_q   <= '0;
      acc_q    <= '0;
      result_q <= '0;
    end else if (start) begin
      busy_q   <= 1'b1;
      mode_q   <= protect;
      done_q   <= 1'b0;
      addr_q   <= '0;
      acc_q    <= '0;
      result_q <= '0;
    end else if (take) begin
      addr_q <= addr_q + 1'b1;
      acc_q  <= acc_next;
      if (last) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        result_q <= final_sum;
      end
    end
  end

  assign checksum = result_q;
  assign done     = done_q;
endmodule

// File: rtl/prog_checksum_chk.sv
module prog_checksum_chk #(
  parameter int SUM_W     = 16,
  parameter int ADDR_W    = 10,
  parameter int LAST_ADDR = 'h3FE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              word_valid,
  input logic              busy_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic              done,
  input logic [SUM_W-1:0]  checksum
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && checksum == '0 && addr_q == '0 && busy_q)); // R2
  AST_ZERO_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> checksum == '0); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !word_valid && !start) |=> $stable(addr_q)); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && word_valid && !start && addr_q == LAST) |=> done); // R8
  AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy_q && word_valid && !start && addr_q == LAST)); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(checksum))); // R10
endmodule

bind prog_checksum prog_checksum_chk #(.SUM_W(SUM_W), .ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .word_valid(word_valid),
  .busy_q(busy_q), .addr_q(addr_q), .done(done), .checksum(checksum)
);

// File: tb/prog_checksum_test.sv
module prog_checksum_test;
  localparam int NWORDS = 'h3FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        word_valid = 1'b0;
  logic [13:0] word_in = '0;
  logic [13:0] cfg_word = '0;
  logic [13:0] id0 = '0, id1 = '0, id2 = '0, id3 = '0;
  logic        protect = 1'b0;
  logic [15:0] checksum;
  logic        done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  prog_checksum uut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_valid(word_valid),
    .word_in(word_in), .cfg_word(cfg_word), .id0(id0), .id1(id1),
    .id2(id2), .id3(id3), .protect(protect), .checksum(checksum), .done(done)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [15:0] pack_ids();
    return {id0[3:0], id1[3:0], id2[3:0], id3[3:0]};
  endfunction

  function automatic logic [15:0] expect_sum(bit prot, logic [15:0] words_sum);
    logic [15:0] cfg_m = {2'b00, cfg_word} & 16'h01FF;
    return prot ? pack_ids() + cfg_m : words_sum + cfg_m;
  endfunction

  function automatic logic [13:0] pattern_word(int pat, int i);
    case (pat)
      0: return 14'h0000;
      1: return 14'h3FFF;
      2: return 14'(i);
      default: return 14'($urandom);
    endcase
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    word_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  // prot_mid: value placed on protect halfway through the run
  task automatic run(string req, bit prot, bit prot_mid, int pat, int gap_pct);
    logic [15:0] sum = '0;
    logic [15:0] exp;
    protect = prot;
    pulse_start();
    check({req, " run output zero"}, {done, checksum} == 17'd0 ? 16'd0 : 16'd1, 16'd0);
    for (int i = 0; i < NWORDS; i++) begin
      while (($urandom % 100) < gap_pct) begin
        word_valid = 1'b0;
        word_in = 14'($urandom);
        @(negedge clk);
      end
      if (i == NWORDS / 2) protect = prot_mid;
      word_valid = 1'b1;
      word_in = pattern_word(pat, i);
      sum = sum + {2'b00, word_in};
      if (i == NWORDS - 1) check({req, " R8 done not early"}, {15'd0, done}, 16'd0);
      @(negedge clk);
    end
    word_valid = 1'b0;
    exp = expect_sum(prot, sum);
    check({req, " R8 done after last"}, {15'd0, done}, 16'd1);
    check({req, " result"}, checksum, exp);
  endtask

  task automatic randomize_side();
    cfg_word = 14'($urandom);
    id0 = 14'($urandom); id1 = 14'($urandom);
    id2 = 14'($urandom); id3 = 14'($urandom);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd4242));
    #1;
    check("R1 checksum after reset", checksum, 16'd0);
    check("R1 done after reset", {15'd0, done}, 16'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // words before any start are outside a run
    word_valid = 1'b1; word_in = 14'h3FFF;
    repeat (4) @(negedge clk);
    word_valid = 1'b0;
    check("R1 R10 pre-start words ignored", {15'd0, done}, 16'd0);

    cfg_word = 14'h3FFF;
    run("R3 zeros", 1'b0, 1'b0, 0, 0);
    check("R3 zeros value", checksum, 16'h01FF);

    cfg_word = 14'h0000;
    run("R5 all ones wrap", 1'b0, 1'b0, 1, 0);
    check("R5 wrap value", checksum, 16'((NWORDS * 32'h3FFF) & 32'hFFFF));

    randomize_side();
    run("R3 ramp", 1'b0, 1'b0, 2, 0);

    randomize_side();
    run("R3 R6 random with gaps", 1'b0, 1'b0, 3, 30);

    cfg_word = 14'h3FFF;
    id0 = 14'h3FF1; id1 = 14'h2AB2; id2 = 14'h1553; id3 = 14'h0004;
    run("R4 directed pack", 1'b1, 1'b1, 3, 0);
    check("R4 pack value", checksum, 16'h1433);

    randomize_side();
    run("R7 protected gaps", 1'b1, 1'b1, 3, 20);

    randomize_side();
    run("R9 protect raised midrun", 1'b0, 1'b1, 3, 5);
    randomize_side();
    run("R9 protect dropped midrun", 1'b1, 1'b0, 3, 5);

    // R10: valid words after done leave the result untouched
    held = checksum;
    word_valid = 1'b1;
    for (int k = 0; k < 6; k++) begin
      word_in = 14'($urandom);
      @(negedge clk);
    end
    word_valid = 1'b0;
    check("R10 done held", {15'd0, done}, 16'd1);
    check("R10 checksum held", checksum, held);

    // R2: restart in mid-run discards the partial sum
    protect = 1'b0;
    pulse_start();
    word_valid = 1'b1;
    for (int k = 0; k < 300; k++) begin
      word_in = 14'h3FFF;
      @(negedge clk);
    end
    word_valid = 1'b0;
    check("R2 busy output zero", checksum, 16'd0);
    cfg_word = 14'h0123;
    run("R2 restart", 1'b0, 1'b0, 0, 0);
    check("R2 restart value", checksum, 16'h0123);

    // R6: noise on word_in with valid low never reaches the sum
    cfg_word = 14'h0000;
    protect = 1'b0;
    pulse_start();
    for (int i = 0; i < NWORDS; i++) begin
      word_valid = 1'b0; word_in = 14'h3FFF;
      @(negedge clk);
      word_valid = 1'b1; word_in = 14'h0001;
      @(negedge clk);
    end
    word_valid = 1'b0;
    check("R6 gaps ignored", checksum, 16'(NWORDS));
    check("R6 done", {15'd0, done}, 16'd1);

    summary();
  end
endmodule